// File: doc/BRIEF.md
# Credit-Gated Strict-Priority Packet Scheduler

This block decides which of several outbound protocol units may place its next packet into a shared transmit buffer. Every unit raises a request with a 2-bit priority and a critical-flow flag. The block also tracks how full the physical-layer transmit buffer is, and from that fill level it works out, for each priority, whether outbound credit is available. A unit whose priority has no credit takes no part in arbitration. Among the units that remain, the highest priority wins. Within one priority, a critical-flow request beats a plain one, and equal requests take turns in round-robin order, one packet per turn.

The buffer depth depends on the port mode: 8 entries when four narrow ports share the buffer, 16 for two medium ports, and 32 for one wide port. Each priority has a programmable required-buffer count. Credit for that priority stops once the fill level reaches the depth minus that count. A grant lasts one packet and ends when the granted unit reports packet-done. The block records the order of granted units and presents that order on a valid/ready output stream, so the physical layer drains entries in grant order.

Back-pressure rules for the order stream: `ord_valid` is high whenever the buffer holds at least one entry, and `ord_unit` then shows the oldest entry. An entry leaves, and the fill level drops by one, on every clock edge where both `ord_valid` and `ord_ready` are high. `ord_ready` has no effect while `ord_valid` is low. On the request side, a unit keeps `req_valid` high until it sees its `grant` bit, and it asserts `pkt_done` only while its grant is high.

Top module: `tx_credit_sched`

## Requirements
- R1: Buffer depth follows `port_mode`: 0 gives 8 entries, 1 gives 16, and 2 or 3 gives 32.
- R2: `credit[p]` is high exactly when required count `wm_cfg[p*6 +: 6]` is below the depth and `occupancy` is below depth minus that count.
- R3: A unit whose priority lacks credit is never granted, and a lower-priority unit that has credit may be granted in its place.
- R4: The highest pending priority is granted first, where a larger numeric `req_prio` value is higher.
- R5: At equal priority, a request with `req_crf` set is granted before one without it.
- R6: Equal-ranked requests are served round robin, one packet per turn. Each priority keeps its own pointer, which moves to the unit after the last one granted; pointers start at unit 0.
- R7: `grant` is one-hot or zero. It rises, together with a one-cycle `enq_pulse`, on the edge after an idle cycle with an eligible request. It holds until the granted unit's `pkt_done` is sampled, falls on that edge, and the next arbitration takes place one cycle later.
- R8: `occupancy` rises by one on each grant and falls by one on each `ord_valid && ord_ready` handshake. It never exceeds 32 and never goes below 0.
- R9: `ord_unit` presents granted unit indices in grant order, and `ord_valid` equals `occupancy != 0`.
- R10: After reset, `grant` is zero, `occupancy` is zero and `ord_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_UNITS | Per-unit packet request |
| req_prio | input | N_UNITS*2 | Per-unit priority, unit i in bits [2i+1:2i] |
| req_crf | input | N_UNITS | Per-unit critical-flow flag |
| pkt_done | input | N_UNITS | Granted unit finished its packet |
| port_mode | input | 2 | Lane configuration selecting buffer depth |
| wm_cfg | input | 4*6 | Required buffer count per priority |
| grant | output | N_UNITS | One-hot grant |
| enq_pulse | output | 1 | One cycle at the start of each grant |
| occupancy | output | 6 | Entries held in the transmit buffer |
| credit | output | 4 | Per-priority credit available |
| ord_valid | output | 1 | Order stream has an entry |
| ord_unit | output | 2 | Unit index of the oldest entry |
| ord_ready | input | 1 | Physical layer drains the oldest entry |

## Verification
The bench fills the buffer one grant at a time. At each fill level it steps through every port mode and compares all four credit bits with the watermark rule. A wrong threshold, an off-by-one at the mode boundary, or a mode decode that treats 3 differently from 2 would show up as a credit bit that flips one level early or late. It starves a high priority of credit and checks that a lower priority is served instead. A design that still ranked a unit without credit would stall or grant the wrong unit. Other tests check round-robin rotation with gaps in the requester set, which catches a pointer that stays put or skips. They also check that the order stream repeats the grant sequence and ignores `ord_ready` when empty, which catches an occupancy that underflows or a FIFO that pops out of order.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

  typedef enum logic [1:0] {
    LANES_QUAD   = 2'd0,
    LANES_DUAL   = 2'd1,
    LANES_SINGLE = 2'd2,
    LANES_SPARE  = 2'd3
  } lane_cfg_e;

  // Entries available to one port for a given lane configuration.
  function automatic int lane_depth(input logic [1:0] mode, input int max_depth);
    case (lane_cfg_e'(mode))
      LANES_QUAD: return max_depth / 4;
      LANES_DUAL: return max_depth / 2;
      default:    return max_depth;
    endcase
  endfunction

endpackage

// File: rtl/tcs_credit.sv
module tcs_credit #(
  parameter int LEVELS    = 4,
  parameter int CNT_W     = 6,
  parameter int MAX_DEPTH = 32
) (
  input  logic [CNT_W-1:0]        occupancy,
  input  logic [1:0]              port_mode,
  input  logic [LEVELS*CNT_W-1:0] wm_cfg,
  output logic [LEVELS-1:0]       credit
);

  logic [CNT_W-1:0] depth;

  always_comb depth = CNT_W'(tcs_pkg::lane_depth(port_mode, MAX_DEPTH));

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    logic [CNT_W-1:0] need;
    assign need      = wm_cfg[l*CNT_W +: CNT_W];
    assign credit[l] = (need < depth) && (occupancy < (depth - need));
  end

endmodule

// File: rtl/tcs_arbiter.sv
module tcs_arbiter #(
  parameter int N      = 4,
  parameter int PRIO_W = 2,
  parameter int UID_W  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        elig,
  input  logic [N*PRIO_W-1:0] prio,
  input  logic [N-1:0]        crf,
  input  logic                advance,
  output logic                win_valid,
  output logic [UID_W-1:0]    win_id
);

  localparam int LEVELS = 1 << PRIO_W;
  localparam int KEY_W  = PRIO_W + 1;

  logic [UID_W-1:0]  ptr [LEVELS];
  logic [KEY_W-1:0]  best_key;
  logic [PRIO_W-1:0] best_prio;
  logic [N-1:0]      cand;
  logic              found;

  // Rank = {priority, critical flag}; take the highest, then rotate.
  always_comb begin
    best_key = '0;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && ({prio[i*PRIO_W +: PRIO_W], crf[i]} > best_key))
        best_key = {prio[i*PRIO_W +: PRIO_W], crf[i]};
    end
    best_prio = best_key[KEY_W-1:1];
    for (int i = 0; i < N; i++)
      cand[i] = elig[i] && ({prio[i*PRIO_W +: PRIO_W], crf[i]} == best_key);
    win_valid = |elig;
    win_id    = '0;
    found     = 1'b0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(ptr[best_prio]) + k) % N;
      if (!found && cand[idx]) begin
        win_id = UID_W'(idx);
        found  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int l = 0; l < LEVELS; l++) ptr[l] <= '0;
    end else if (advance) begin
      ptr[best_prio] <= (int'(win_id) == N - 1) ? '0 : win_id + UID_W'(1);
    end
  end

endmodule

// File: rtl/tcs_order_fifo.sv
module tcs_order_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 2,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  output logic             out_valid,
  output logic [W-1:0]     out_data,
  output logic [CNT_W-1:0] count
);

  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;

  assign out_valid = (count != '0);
  assign out_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + AW'(1);
      if (pop)  rd_ptr <= rd_ptr + AW'(1);
      case ({push, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/tx_credit_sched.sv
module tx_credit_sched #(
  parameter int N_UNITS   = 4,
  parameter int PRIO_W    = 2,
  parameter int MAX_DEPTH = 32,
  localparam int UID_W    = $clog2(N_UNITS),
  localparam int CNT_W    = $clog2(MAX_DEPTH + 1),
  localparam int LEVELS   = 1 << PRIO_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_UNITS-1:0]        req_valid,
  input  logic [N_UNITS*PRIO_W-1:0] req_prio,
  input  logic [N_UNITS-1:0]        req_crf,
  input  logic [N_UNITS-1:0]        pkt_done,
  input  logic [1:0]                port_mode,
  input  logic [LEVELS*CNT_W-1:0]   wm_cfg,
  output logic [N_UNITS-1:0]        grant,
  output logic                      enq_pulse,
  output logic [CNT_W-1:0]          occupancy,
  output logic [LEVELS-1:0]         credit,
  output logic                      ord_valid,
  output logic [UID_W-1:0]          ord_unit,
  input  logic                      ord_ready
);

  logic               busy;
  logic [N_UNITS-1:0] elig;
  logic               win_valid;
  logic [UID_W-1:0]   win_id;
  logic               take;
  logic               drain;

  for (genvar i = 0; i < N_UNITS; i++) begin : g_elig
    assign elig[i] = req_valid[i] && !busy && credit[req_prio[i*PRIO_W +: PRIO_W]];
  end

  assign take  = win_valid;
  assign drain = ord_valid && ord_ready;

  tcs_credit #(.LEVELS(LEVELS), .CNT_W(CNT_W), .MAX_DEPTH(MAX_DEPTH)) u_credit (
    .occupancy (occupancy),
    .port_mode (port_mode),
    .wm_cfg    (wm_cfg),
    .credit    (credit)
  );

  tcs_arbiter #(.N(N_UNITS), .PRIO_W(PRIO_W), .UID_W(UID_W)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .elig      (elig),
    .prio      (req_prio),
    .crf       (req_crf),
    .advance   (take),
    .win_valid (win_valid),
    .win_id    (win_id)
  );

  tcs_order_fifo #(.DEPTH(MAX_DEPTH), .W(UID_W), .CNT_W(CNT_W)) u_order (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (take),
    .push_data (win_id),
    .pop       (drain),
    .out_valid (ord_valid),
    .out_data  (ord_unit),
    .count     (occupancy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      grant     <= '0;
      enq_pulse <= 1'b0;
    end else begin
      enq_pulse <= take;
      if (take) begin
        busy  <= 1'b1;
        grant <= N_UNITS'(1) << win_id;
      end else if (busy && |(grant & pkt_done)) begin
        busy  <= 1'b0;
        grant <= '0;
      end
    end
  end

endmodule

// File: rtl/tcs_checker.sv
module tcs_checker #(
  parameter int N_UNITS   = 4,
  parameter int MAX_DEPTH = 32,
  parameter int CNT_W     = 6,
  parameter int LEVELS    = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_UNITS-1:0] pkt_done,
  input logic [N_UNITS-1:0] grant,
  input logic               enq_pulse,
  input logic [CNT_W-1:0]   occupancy,
  input logic [LEVELS-1:0]  credit,
  input logic               ord_valid,
  input logic               ord_ready
);

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R7

  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && (grant & pkt_done) == '0) |=> grant == $past(grant)); // R7

  AST_GRANT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & pkt_done) != '0) |=> grant == '0); // R7

  AST_ENQ_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    enq_pulse |-> (grant != '0 && $past(grant) == '0)); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occupancy) <= MAX_DEPTH); // R8

  AST_OCC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(rst_n) |-> int'(occupancy) == int'($past(occupancy)) + int'(enq_pulse)
                                       - int'($past(ord_valid && ord_ready))); // R8

  AST_FULL_NO_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(occupancy) >= MAX_DEPTH) |-> credit == '0); // R2

  AST_ORD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    ord_valid == (occupancy != '0)); // R9

endmodule

bind tx_credit_sched tcs_checker #(
  .N_UNITS(N_UNITS), .MAX_DEPTH(MAX_DEPTH), .CNT_W(CNT_W), .LEVELS(LEVELS)
) u_tcs_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .pkt_done  (pkt_done),
  .grant     (grant),
  .enq_pulse (enq_pulse),
  .occupancy (occupancy),
  .credit    (credit),
  .ord_valid (ord_valid),
  .ord_ready (ord_ready)
);

// File: tb/test_tx_credit_sched.sv
module test_tx_credit_sched;

  localparam int N  = 4;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  req_valid;
  logic [2*N-1:0] req_prio;
  logic [N-1:0]  req_crf;
  logic [N-1:0]  pkt_done;
  logic [1:0]    port_mode;
  logic [4*CW-1:0] wm_cfg;
  logic [N-1:0]  grant;
  logic          enq_pulse;
  logic [CW-1:0] occupancy;
  logic [3:0]    credit;
  logic          ord_valid;
  logic [1:0]    ord_unit;
  logic          ord_ready;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  tx_credit_sched i_tx_credit_sched (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_prio(req_prio),
    .req_crf(req_crf), .pkt_done(pkt_done), .port_mode(port_mode), .wm_cfg(wm_cfg),
    .grant(grant), .enq_pulse(enq_pulse), .occupancy(occupancy), .credit(credit),
    .ord_valid(ord_valid), .ord_unit(ord_unit), .ord_ready(ord_ready)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_credit(input int occ, input int mode, input logic [4*CW-1:0] wm);
    int d;
    int r;
    d = (mode == 0) ? 8 : (mode == 1) ? 16 : 32;
    r = 0;
    for (int p = 0; p < 4; p++) begin
      int need;
      need = int'(wm[p*CW +: CW]);
      if (need < d && occ < d - need) r |= (1 << p);
    end
    return r;
  endfunction

  task automatic set_req(input int u, input int p, input bit c, input bit v);
    req_prio[2*u +: 2] = 2'(p);
    req_crf[u]   = c;
    req_valid[u] = v;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_valid = '0; req_prio = '0; req_crf = '0; pkt_done = '0;
    port_mode = 2'd2; wm_cfg = '0; ord_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Waits for a grant (sampled at negedge), then ends its packet.
  task automatic serve(output int id);
    id = -1;
    for (int t = 0; t < 40; t++) begin
      @(negedge clk);
      if (grant != '0) begin
        for (int i = 0; i < N; i++) if (grant[i]) id = i;
        pkt_done = grant;
        @(negedge clk);
        pkt_done = '0;
        return;
      end
    end
  endtask

  task automatic drain(input int n);
    for (int k = 0; k < n; k++) begin
      ord_ready = 1'b1;
      @(negedge clk);
    end
    ord_ready = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    check("R10 grant after reset", int'(grant), 0);
    check("R10 occupancy after reset", int'(occupancy), 0);
    check("R10 ord_valid after reset", int'(ord_valid), 0);
    check("R2 credit at empty", int'(credit), 15);
  endtask

  task automatic t_hold();
    do_reset();
    set_req(2, 1, 0, 1);
    @(posedge clk); #1;
    check("R7 grant rises on first edge", int'(grant), 4);
    check("R7 enq pulse with grant", int'(enq_pulse), 1);
    @(posedge clk); #1;
    check("R7 enq pulse one cycle", int'(enq_pulse), 0);
    repeat (3) @(posedge clk);
    #1 check("R7 grant held without done", int'(grant), 4);
    @(negedge clk); pkt_done = 4'b0100;
    @(posedge clk); #1;
    pkt_done = '0;
    check("R7 grant falls on done", int'(grant), 0);
    @(posedge clk); #1;
    check("R7 next arbitration after gap", int'(grant), 4);
    check("R8 two grants counted", int'(occupancy), 2);
    @(negedge clk); pkt_done = 4'b0100; req_valid = '0;
    @(negedge clk); pkt_done = '0;
  endtask

  task automatic t_priority();
    int id;
    do_reset();
    set_req(0, 1, 0, 1); set_req(1, 2, 0, 1); set_req(2, 1, 0, 1); set_req(3, 0, 0, 1);
    serve(id); check("R4 highest priority first", id, 1);
    req_valid[1] = 1'b0;
    serve(id); check("R6 prio1 rotation start", id, 0);
    serve(id); check("R6 prio1 skips gap", id, 2);
    serve(id); check("R6 prio1 wraps", id, 0);
    req_valid[0] = 1'b0; req_valid[2] = 1'b0;
    serve(id); check("R4 lowest served last", id, 3);
    req_valid = '0;
  endtask

  task automatic t_crf();
    int id;
    do_reset();
    set_req(0, 2, 0, 1); set_req(1, 2, 1, 1); set_req(2, 1, 1, 1);
    serve(id); check("R5 critical flag wins tie", id, 1);
    serve(id); check("R5 critical flag keeps winning", id, 1);
    req_valid[1] = 1'b0;
    serve(id); check("R5 flag below higher priority", id, 0);
    req_valid = '0;
  endtask

  task automatic t_round_robin_order();
    int id;
    int seq[6] = '{0, 1, 2, 3, 0, 1};
    do_reset();
    for (int u = 0; u < N; u++) set_req(u, 3, 0, 1);
    for (int k = 0; k < 6; k++) begin
      serve(id);
      check("R6 round robin sequence", id, seq[k]);
    end
    req_valid = '0;
    @(negedge clk);
    check("R8 occupancy after six grants", int'(occupancy), 6);
    for (int k = 0; k < 6; k++) begin
      check("R9 ord_valid while filled", int'(ord_valid), 1);
      check("R9 order matches grants", int'(ord_unit), seq[k]);
      drain(1);
    end
    check("R8 occupancy drained", int'(occupancy), 0);
    check("R9 ord_valid when empty", int'(ord_valid), 0);
    drain(2);
    check("R8 no underflow on empty drain", int'(occupancy), 0);
  endtask

  task automatic t_credit_sweep();
    int id;
    do_reset();
    wm_cfg = {6'd0, 6'd3, 6'd9, 6'd40};
    set_req(0, 3, 0, 1);
    for (int k = 1; k <= 32; k++) begin
      @(negedge clk);
      for (int t = 0; t < 10 && grant == '0; t++) @(negedge clk);
      check("R8 occupancy per grant", int'(occupancy), k);
      for (int m = 0; m < 4; m++) begin
        port_mode = 2'(m);
        #0.5;
        check("R1 R2 credit vs mode and level", int'(credit), exp_credit(k, m, wm_cfg));
      end
      port_mode = 2'd2;
      pkt_done = grant;
      @(negedge clk);
      pkt_done = '0;
    end
    serve(id);
    check("R3 no grant when full", id, -1);
    check("R8 occupancy saturates", int'(occupancy), 32);
    req_valid = '0;
  endtask

  task automatic t_credit_exclusion();
    int id;
    do_reset();
    port_mode = 2'd0;
    wm_cfg = {6'd0, 6'd3, 6'd0, 6'd0};
    set_req(0, 2, 0, 1); set_req(1, 0, 0, 1);
    for (int k = 0; k < 5; k++) begin
      serve(id); check("R4 prio2 while credited", id, 0);
    end
    check("R2 prio2 credit gone at 5 of 8", int'(credit[2]), 0);
    serve(id); check("R3 lower priority takes over", id, 1);
    serve(id); check("R3 lower priority continues", id, 1);
    serve(id); check("R3 lower priority until 8", id, 1);
    serve(id); check("R1 quad mode stops at 8", id, -1);
    req_valid = '0;
    drain(4);
    check("R8 occupancy after drain", int'(occupancy), 4);
    req_valid = 4'b0011;
    serve(id); check("R3 credit returns to prio2", id, 0);
    req_valid = '0;
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=0", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_hold();
    t_priority();
    t_crf();
    t_round_robin_order();
    t_credit_sweep();
    t_credit_exclusion();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule